// File: doc/BRIEF.md
# Bootstrap MMIO Register Window

This block gives early-boot firmware a plain, well-behaved register space to talk to before any real peripheral models exist. Firmware writes 32-bit words into a 16-bit byte-addressed window using a single-cycle write strobe with per-byte enables, and reads them back through a separate read strobe. Every word starts at zero after reset, so a read-modify-write on a register that has never been touched sets bits correctly instead of merging with unknown data.

Reads are registered: the data for a read strobe appears one cycle later along with a one-cycle valid pulse, and then stays put until the next read completes. One offset, 0x1814, is a status intercept. It always reads as a parameterised ready constant, all ones by default, so polling loops waiting on bit 28 finish at once. Writes to it still go into storage, but storage is never read back from that offset. The storage depth is a parameter. Word indices wrap modulo that depth, which lets a small instance stand in for the full window.

Top module: `bootstrap_mmio_window`

## Requirements
- R1: Addressing is by 32-bit word. Address bits [1:0] are ignored on both ports, so 0x0400, 0x0401, 0x0402 and 0x0403 all reach the same word.
- R2: After rst_n has been low, every word except the intercept offset reads as 0x00000000.
- R3: A read strobe sampled on a rising edge makes rd_valid high for exactly the following cycle, with rd_data holding the addressed word. rd_valid is low in all other cycles.
- R4: Write enable bit i (wr_be[i]) updates only data bits [8i+7:8i]. Lanes that are not enabled keep their previous contents, for any single byte and for either 16-bit half.
- R5: A write with wr_be equal to 4'b0000 leaves the addressed word unchanged.
- R6: Distinct word offsets are independent. A write never alters another offset, and a later full write to an offset replaces its earlier value entirely.
- R7: A read of word offset 0x1814 returns parameter READY_VALUE (default 0xFFFFFFFF, so bit 28 reads as 1), both before and after that offset is written.
- R8: Offsets 0x1810 and 0x1818 are ordinary read/write words, and a write to 0x1814 does not disturb them.
- R9: When a read and a write hit the same word on the same edge, the read returns the value stored before that write. The new value is visible to the next read.
- R10: rd_data holds its value in every cycle where no read completes.
- R11: The word index is the address word number modulo DEPTH_WORDS (default 2048). With the default depth, address 0x2010 reaches the same storage word as 0x0010.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low reset, clears storage and read outputs |
| wr_en | input | 1 | Write strobe, one cycle per write |
| wr_addr | input | 16 | Write byte address |
| wr_data | input | 32 | Write data |
| wr_be | input | 4 | Byte-lane enables for the write |
| rd_en | input | 1 | Read strobe |
| rd_addr | input | 16 | Read byte address |
| rd_data | output | 32 | Registered read data |
| rd_valid | output | 1 | One-cycle pulse marking a completed read |

## Verification
The hardest case to reach is a read and a write hitting the same word on the same edge, because normal bus traffic keeps them apart. The bench raises both strobes in a single cycle on a word it seeded beforehand, checks that the old value comes back, and then reads again to see the new one. Storage hidden under the intercept offset cannot be seen at the ports. The bench therefore writes the intercept and checks that the constant still comes back and that both neighbouring words are unchanged.

// File: rtl/bmw_pkg.sv
package bmw_pkg;
  localparam int unsigned ADDR_W = 16;
  localparam int unsigned DATA_W = 32;
  localparam int unsigned LANES  = DATA_W / 8;

  // Expand per-lane enables into a bit mask.
  function automatic logic [DATA_W-1:0] lane_mask(input logic [LANES-1:0] be);
    logic [DATA_W-1:0] m;
    for (int i = 0; i < LANES; i++) m[8*i +: 8] = {8{be[i]}};
    return m;
  endfunction

  // Merge new data into an old word, lane by lane.
  function automatic logic [DATA_W-1:0] merge_word(input logic [DATA_W-1:0] old_w,
                                                   input logic [DATA_W-1:0] new_w,
                                                   input logic [LANES-1:0]  be);
    logic [DATA_W-1:0] m;
    m = lane_mask(be);
    return (old_w & ~m) | (new_w & m);
  endfunction

  // Word number of a byte address (low two bits dropped).
  function automatic logic [ADDR_W-3:0] word_num(input logic [ADDR_W-1:0] a);
    return a[ADDR_W-1:2];
  endfunction
endpackage

// File: rtl/bmw_store.sv
module bmw_store
  import bmw_pkg::*;
#(
  parameter int unsigned DEPTH_WORDS = 2048,
  localparam int unsigned IDX_W = $clog2(DEPTH_WORDS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [IDX_W-1:0]  wr_idx,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [LANES-1:0]  wr_be,
  input  logic [IDX_W-1:0]  rd_idx,
  output logic [DATA_W-1:0] rd_word
);
  logic [DATA_W-1:0] mem [DEPTH_WORDS];

  // Lane-merged word and write event, brought out for checking.
  logic [DATA_W-1:0] merged_word;
  logic              wr_fire;
  assign merged_word = merge_word(mem[wr_idx], wr_data, wr_be);
  assign wr_fire     = wr_en && (wr_be != '0);

  generate
    for (genvar w = 0; w < DEPTH_WORDS; w++) begin : g_word
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)                                   mem[w] <= '0;
        else if (wr_fire && (wr_idx == IDX_W'(w)))    mem[w] <= merged_word;
      end
    end
  endgenerate

  // Asynchronous lookup; the read port registers it, so same-edge
  // writes are not yet visible (old value returned).
  assign rd_word = mem[rd_idx];

  // R5: zero enables leave the addressed word untouched
  p_zero_be_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_be == '0 && rd_idx == wr_idx) |=> $stable(rd_word) || (rd_idx != $past(rd_idx)));

  // R4: merged word keeps every disabled lane of the old word
  p_merge_keeps_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |-> ((merged_word & ~lane_mask(wr_be)) == (mem[wr_idx] & ~lane_mask(wr_be))));
endmodule

// File: rtl/bmw_read_port.sv
module bmw_read_port
  import bmw_pkg::*;
#(
  parameter logic [DATA_W-1:0] READY_VALUE = 32'hFFFF_FFFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rd_en,
  input  logic              ready_hit,
  input  logic [DATA_W-1:0] stored_word,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  logic [DATA_W-1:0] next_word;
  assign next_word = ready_hit ? READY_VALUE : stored_word;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= next_word;
    end
  end

  // R3: every strobe yields a valid pulse next cycle
  p_valid_follows_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);
  // R3: no valid without a strobe the cycle before
  p_valid_needs_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);
  // R7: intercept offset returns the ready constant
  p_ready_intercept_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && ready_hit) |=> (rd_data == READY_VALUE));
  // R10: data holds while no read completes
  p_data_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> $stable(rd_data));
endmodule

// File: rtl/bootstrap_mmio_window.sv
module bootstrap_mmio_window
  import bmw_pkg::*;
#(
  parameter int unsigned        DEPTH_WORDS  = 2048,
  parameter logic [15:0]        READY_OFFSET = 16'h1814,
  parameter logic [31:0]        READY_VALUE  = 32'hFFFF_FFFF
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [15:0] wr_addr,
  input  logic [31:0] wr_data,
  input  logic [3:0]  wr_be,
  input  logic        rd_en,
  input  logic [15:0] rd_addr,
  output logic [31:0] rd_data,
  output logic        rd_valid
);
  localparam int unsigned IDX_W = $clog2(DEPTH_WORDS);

  // Decoded events, named for the checks.
  logic [IDX_W-1:0] wr_idx, rd_idx;
  logic             ready_hit;
  logic [31:0]      stored_word;

  assign wr_idx    = IDX_W'(word_num(wr_addr));
  assign rd_idx    = IDX_W'(word_num(rd_addr));
  assign ready_hit = (word_num(rd_addr) == word_num(READY_OFFSET));

  bmw_store #(.DEPTH_WORDS(DEPTH_WORDS)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (wr_en),
    .wr_idx  (wr_idx),
    .wr_data (wr_data),
    .wr_be   (wr_be),
    .rd_idx  (rd_idx),
    .rd_word (stored_word)
  );

  bmw_read_port #(.READY_VALUE(READY_VALUE)) u_rport (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_en       (rd_en),
    .ready_hit   (ready_hit),
    .stored_word (stored_word),
    .rd_data     (rd_data),
    .rd_valid    (rd_valid)
  );

  // R1: addresses differing only in bits [1:0] map to one word
  p_word_aliasing_r1: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_addr[15:2] == rd_addr[15:2]) |-> (wr_idx == rd_idx));
endmodule

// File: tb/tb_bootstrap_mmio_window.sv
module tb_bootstrap_mmio_window;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        wr_en;
  logic [15:0] wr_addr;
  logic [31:0] wr_data;
  logic [3:0]  wr_be;
  logic        rd_en;
  logic [15:0] rd_addr;
  logic [31:0] rd_data;
  logic        rd_valid;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #5 clk = ~clk;

  bootstrap_mmio_window dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .wr_be(wr_be), .rd_en(rd_en), .rd_addr(rd_addr),
    .rd_data(rd_data), .rd_valid(rd_valid));

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_checks++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s got=0x%08h exp=0x%08h", req, got, exp);
    end
  endtask

  // Independent restatement of lane merging: byte by byte.
  function automatic logic [31:0] expect_merge(input logic [31:0] o, input logic [31:0] n,
                                               input logic [3:0] be);
    logic [31:0] r;
    r = o;
    for (int b = 0; b < 4; b++) if (be[b]) r[b*8 +: 8] = n[b*8 +: 8];
    return r;
  endfunction

  task automatic wr(input logic [15:0] a, input logic [31:0] d, input logic [3:0] be);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = a; wr_data = d; wr_be = be;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0;
  endtask

  // Strobe one cycle, sample after the capturing edge.
  task automatic rd(input logic [15:0] a, output logic [31:0] d, output logic v);
    @(negedge clk);
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  task automatic t_reset;
    logic [31:0] d; logic v;
    check("R3 rd_valid low after reset", {31'd0, rd_valid}, 32'd0);
    rd(16'h0010, d, v); check("R2 reset zero 0x0010", d, 32'd0);
    rd(16'h1000, d, v); check("R2 reset zero 0x1000", d, 32'd0);
  endtask

  task automatic t_latency;
    logic [31:0] d; logic v;
    wr(16'h0010, 32'hAABB_CCDD, 4'hF);
    rd(16'h0010, d, v);
    check("R3 valid pulse", {31'd0, v}, 32'd1);
    check("R3 data", d, 32'hAABB_CCDD);
    @(negedge clk);
    check("R3 valid drops", {31'd0, rd_valid}, 32'd0);
    wr(16'h0020, 32'h0BAD_0BAD, 4'hF);
    repeat (3) @(negedge clk);
    check("R10 data held", rd_data, 32'hAABB_CCDD);
  endtask

  task automatic t_alias;
    logic [31:0] d; logic v;
    wr(16'h0400, 32'hCAFE_BABE, 4'hF);
    for (int k = 1; k < 4; k++) begin
      rd(16'h0400 + 16'(k), d, v); check("R1 low bits ignored", d, 32'hCAFE_BABE);
    end
  endtask

  task automatic t_lanes;
    logic [31:0] d; logic v;
    logic [3:0] pats [6] = '{4'b0001, 4'b0010, 4'b0100, 4'b1000, 4'b0011, 4'b1100};
    for (int k = 0; k < 6; k++) begin
      wr(16'h0500 + 16'(4*k), 32'h1122_3344, 4'hF);
      wr(16'h0500 + 16'(4*k), 32'hA5C3_96E7, pats[k]);
      rd(16'h0500 + 16'(4*k), d, v);
      check("R4 lane merge", d, expect_merge(32'h1122_3344, 32'hA5C3_96E7, pats[k]));
    end
  endtask

  task automatic t_zero_be;
    logic [31:0] d; logic v;
    wr(16'h0700, 32'hDEAD_BEEF, 4'hF);
    wr(16'h0700, 32'hFFFF_FFFF, 4'h0);
    rd(16'h0700, d, v); check("R5 zero enables no change", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_distinct;
    logic [31:0] d; logic v;
    wr(16'h0100, 32'h1111_1111, 4'hF);
    wr(16'h0200, 32'h2222_2222, 4'hF);
    wr(16'h0104, 32'h3333_3333, 4'hF);
    rd(16'h0100, d, v); check("R6 distinct 0x0100", d, 32'h1111_1111);
    rd(16'h0200, d, v); check("R6 distinct 0x0200", d, 32'h2222_2222);
    rd(16'h0104, d, v); check("R6 distinct 0x0104", d, 32'h3333_3333);
    wr(16'h0100, 32'h5555_5555, 4'hF);
    rd(16'h0100, d, v); check("R6 overwrite", d, 32'h5555_5555);
  endtask

  task automatic t_intercept;
    logic [31:0] d; logic v;
    rd(16'h1814, d, v); check("R7 ready before write", d, 32'hFFFF_FFFF);
    check("R7 bit 28 set", {31'd0, d[28]}, 32'd1);
    wr(16'h1810, 32'hAAAA_AAAA, 4'hF);
    wr(16'h1818, 32'hBBBB_BBBB, 4'hF);
    wr(16'h1814, 32'h0000_0000, 4'hF);
    rd(16'h1816, d, v); check("R7 ready after write", d, 32'hFFFF_FFFF);
    rd(16'h1810, d, v); check("R8 neighbour low", d, 32'hAAAA_AAAA);
    rd(16'h1818, d, v); check("R8 neighbour high", d, 32'hBBBB_BBBB);
  endtask

  task automatic t_same_cycle;
    logic [31:0] d;
    wr(16'h0900, 32'h0123_4567, 4'hF);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 16'h0900; wr_data = 32'h89AB_CDEF; wr_be = 4'hF;
    rd_en = 1'b1; rd_addr = 16'h0900;
    @(negedge clk);
    wr_en = 1'b0; wr_be = 4'h0; rd_en = 1'b0;
    d = rd_data;
    check("R9 read sees old value", d, 32'h0123_4567);
    begin
      logic v;
      rd(16'h0900, d, v); check("R9 next read sees new", d, 32'h89AB_CDEF);
    end
  endtask

  task automatic t_wrap;
    logic [31:0] d; logic v;
    wr(16'h2010, 32'h7777_0001, 4'hF);
    rd(16'h0010, d, v); check("R11 index wraps at depth", d, 32'h7777_0001);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0; wr_be = '0;
    rd_en = 1'b0; rd_addr = '0;
    repeat (4) @(posedge clk);
    @(negedge clk); rst_n = 1'b1;
    t_reset();
    t_latency();
    t_alias();
    t_lanes();
    t_zero_be();
    t_distinct();
    t_intercept();
    t_same_cycle();
    t_wrap();
    if (!done) begin
      done = 1'b1;
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      n_checks++; n_fail++;
      $display("FAIL watchdog expired got=running exp=finished");
      $display("  == %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
      $finish;
    end
  end
endmodule